// File: doc/BRIEF.md
# Path Signature Compressor

This block watches one path-checking state machine and squeezes the whole route that machine takes through its states into a single 10-bit signature. Each time the watched machine changes state, the code of the state it has just entered is folded into a multiple-input signature register by polynomial division. The polynomial is 1 + x^3 + x^10. The register holds its seed while the watched machine rests in its idle state. Cycles with no state change leave it untouched.

When the watched machine re-enters idle, or falls into its error state, the path is complete. The block then issues a one-cycle save request that carries the final signature, terminal state code included, and reseeds the register for the next path. A trace store downstream records one word per path instead of one word per transition. The watched machine's state codes and the choice of which codes mean idle and error belong to the surrounding design. Here they arrive only as a code bus and two flags.

Top module: `path_sig_compressor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sig` equals the parameter `SEED`, `save_req` is 0 and `save_sig` is 0.
- R2: In a cycle with `state_chg` high and neither `in_idle` nor `in_error` high, on the next edge `sig` becomes the old value shifted one place toward the MSB. A zero enters bit 0. If the old bit 9 was 1, bits 0 and 3 are inverted. The 4-bit `state_code` is XORed into bits 3..0.
- R3: In a cycle with `state_chg` low and `in_idle` low, `sig` keeps its value on the next edge. This holds whatever `state_code` carries, and also while `in_error` is high.
- R4: In a cycle with `in_idle` high and `state_chg` low, `sig` equals `SEED` after the next edge.
- R5: In a cycle with `state_chg` and `in_idle` both high, the next edge sets `save_req` to 1 and `save_sig` to the R2 fold of the old `sig` with `state_code`. The same edge sets `sig` to `SEED`.
- R6: In a cycle with `state_chg` and `in_error` both high, the next edge also gives `save_req` = 1, `save_sig` = the fold including the error code, and `sig` = `SEED`. This holds even when the error is entered straight from idle.
- R7: `save_req` is 0 after any edge not preceded by a cycle that completed a path. `save_sig` keeps its value from one save to the next.
- R8: Two paths of equal length that differ in exactly one state code save different signatures. With idle coded 0 and error coded 15, the 24 paths 1, x, 3, T have pairwise-distinct saved signatures, for x in 2..13 and T in {0, 15}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| state_code | input | 4 | Code of the state the watched machine has just entered |
| state_chg | input | 1 | High for one cycle per state change of the watched machine |
| in_idle | input | 1 | The watched machine is in (or has just entered) idle |
| in_error | input | 1 | The watched machine is in (or has just entered) its error state |
| sig | output | 10 | Running signature of the current path |
| save_req | output | 1 | One-cycle request to store a completed path |
| save_sig | output | 10 | Signature of the last completed path |

## Verification
The bench builds the block with its default parameters: a 10-bit register, taps at x^0 and x^3, and a seed of 0x001. A nonzero seed makes a missed reseed visible. A twelve-transition path pushes ones through bit 9, so the feedback taps are exercised and not only the plain shift. Back-to-back paths with no idle gap, and error entered straight from idle, cover the end-of-path corner cases. A family of 24 equal-length paths is checked for unique signatures, covering both legal and error-terminated paths.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int unsigned PSC_SIG_W  = 10;
    localparam int unsigned PSC_CODE_W = 4;
    // taps of 1 + x^3 + x^10 below the top term
    localparam logic [PSC_SIG_W-1:0] PSC_TAPS = 10'h009;
    localparam logic [PSC_SIG_W-1:0] PSC_SEED = 10'h001;

    // decoded per-cycle control for the signature register
    typedef struct packed {
        logic fold;    // take the folded value
        logic finish;  // path ends on this change
        logic reseed;  // load the seed
    } psc_ctl_t;

    function automatic psc_ctl_t psc_decode(input logic chg,
                                            input logic idle,
                                            input logic err);
        psc_ctl_t c;
        c.fold   = chg;
        c.finish = chg & (idle | err);
        c.reseed = (chg & (idle | err)) | (idle & ~chg);
        return c;
    endfunction

endpackage

// File: rtl/psc_fold.sv
module psc_fold #(
    parameter int unsigned           SIG_W  = 10,
    parameter int unsigned           CODE_W = 4,
    parameter logic [SIG_W-1:0]      TAPS   = 10'h009
) (
    input  logic [SIG_W-1:0]  cur,
    input  logic [CODE_W-1:0] code,
    output logic [SIG_W-1:0]  nxt
);
    localparam int unsigned MSB = SIG_W - 1;

    logic [SIG_W-1:0] shl;
    logic [SIG_W-1:0] inj;
    logic             fb;

    assign fb = cur[MSB];

    for (genvar i = 0; i < SIG_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign shl[i] = 1'b0;
        end else begin : g_up
            assign shl[i] = cur[i-1];
        end
        if (i < CODE_W) begin : g_in
            assign inj[i] = code[i];
        end else begin : g_noin
            assign inj[i] = 1'b0;
        end
        assign nxt[i] = shl[i] ^ (TAPS[i] & fb) ^ inj[i];
    end

endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
    import psc_pkg::*;
(
    input  logic     state_chg,
    input  logic     in_idle,
    input  logic     in_error,
    output psc_ctl_t ctl
);
    always_comb begin
        ctl = psc_decode(state_chg, in_idle, in_error);
    end
endmodule

// File: rtl/psc_store.sv
module psc_store
    import psc_pkg::*;
#(
    parameter int unsigned      SIG_W = 10,
    parameter logic [SIG_W-1:0] SEED  = 10'h001
) (
    input  logic             clk,
    input  logic             rst,
    input  psc_ctl_t         ctl,
    input  logic [SIG_W-1:0] folded,
    output logic [SIG_W-1:0] sig_q,
    output logic             save_q,
    output logic [SIG_W-1:0] save_sig_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q      <= SEED;
            save_q     <= 1'b0;
            save_sig_q <= '0;
        end else begin
            save_q <= ctl.finish;
            if (ctl.finish) begin
                save_sig_q <= folded;
            end
            if (ctl.reseed) begin
                sig_q <= SEED;
            end else if (ctl.fold) begin
                sig_q <= folded;
            end
        end
    end
endmodule

// File: rtl/path_sig_compressor.sv
module path_sig_compressor
    import psc_pkg::*;
#(
    parameter int unsigned      SIG_W  = PSC_SIG_W,
    parameter int unsigned      CODE_W = PSC_CODE_W,
    parameter logic [SIG_W-1:0] TAPS   = PSC_TAPS,
    parameter logic [SIG_W-1:0] SEED   = PSC_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] state_code,
    input  logic              state_chg,
    input  logic              in_idle,
    input  logic              in_error,
    output logic [SIG_W-1:0]  sig,
    output logic              save_req,
    output logic [SIG_W-1:0]  save_sig
);
    psc_ctl_t         ctl;
    logic [SIG_W-1:0] folded;

    psc_ctrl u_ctrl (
        .state_chg (state_chg),
        .in_idle   (in_idle),
        .in_error  (in_error),
        .ctl       (ctl)
    );

    psc_fold #(
        .SIG_W  (SIG_W),
        .CODE_W (CODE_W),
        .TAPS   (TAPS)
    ) u_fold (
        .cur  (sig),
        .code (state_code),
        .nxt  (folded)
    );

    psc_store #(
        .SIG_W (SIG_W),
        .SEED  (SEED)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .folded     (folded),
        .sig_q      (sig),
        .save_q     (save_req),
        .save_sig_q (save_sig)
    );
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int unsigned      SIG_W  = 10,
    parameter int unsigned      CODE_W = 4,
    parameter logic [SIG_W-1:0] SEED   = 10'h001
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] state_code,
    input logic              state_chg,
    input logic              in_idle,
    input logic              in_error,
    input logic [SIG_W-1:0]  sig,
    input logic              save_req,
    input logic [SIG_W-1:0]  save_sig
);
    logic path_done;
    assign path_done = state_chg & (in_idle | in_error);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sig == SEED && !save_req && save_sig == '0));

    // R3
    a_r3_hold_no_change: assert property (@(posedge clk) disable iff (rst)
        (!state_chg && !in_idle) |=> (sig == $past(sig)));

    // R4
    a_r4_idle_seed: assert property (@(posedge clk) disable iff (rst)
        (in_idle && !state_chg) |=> (sig == SEED));

    // R5
    a_r5_idle_end: assert property (@(posedge clk) disable iff (rst)
        (state_chg && in_idle) |=> (save_req && sig == SEED));

    // R6
    a_r6_error_end: assert property (@(posedge clk) disable iff (rst)
        (state_chg && in_error) |=> (save_req && sig == SEED));

    // R7
    a_r7_no_spurious_save: assert property (@(posedge clk) disable iff (rst)
        !path_done |=> !save_req);

    // R7
    a_r7_save_sig_held: assert property (@(posedge clk) disable iff (rst)
        !path_done |=> $stable(save_sig));

    // R2: code bits reach the register only through a change strobe
    a_r2_code_ignored_idle_gap: assert property (@(posedge clk) disable iff (rst)
        (!state_chg && !in_idle && !in_error && state_code != '0) |=> $stable(sig));
endmodule

bind path_sig_compressor psc_checker #(
    .SIG_W  (SIG_W),
    .CODE_W (CODE_W),
    .SEED   (SEED)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_code (state_code),
    .state_chg  (state_chg),
    .in_idle    (in_idle),
    .in_error   (in_error),
    .sig        (sig),
    .save_req   (save_req),
    .save_sig   (save_sig)
);

// File: tb/sim_path_sig_compressor.sv
`timescale 1ns/100ps
module sim_path_sig_compressor;

    localparam logic [9:0] SEED = 10'h001;
    localparam logic [3:0] C_IDLE = 4'd0;
    localparam logic [3:0] C_ERR  = 4'd15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] state_code = '0;
    logic       state_chg = 1'b0;
    logic       in_idle = 1'b1;
    logic       in_error = 1'b0;
    logic [9:0] sig;
    logic       save_req;
    logic [9:0] save_sig;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    path_sig_compressor u0 (
        .clk        (clk),
        .rst        (rst),
        .state_code (state_code),
        .state_chg  (state_chg),
        .in_idle    (in_idle),
        .in_error   (in_error),
        .sig        (sig),
        .save_req   (save_req),
        .save_sig   (save_sig)
    );

    // division by 1 + x^3 + x^10 with a 4-bit parallel input (R2)
    function automatic logic [9:0] model_fold(logic [9:0] s, logic [3:0] c);
        logic [9:0] t;
        t = {s[8:0], 1'b0};
        if (s[9]) t = t ^ 10'b00_0000_1001;
        t = t ^ {6'd0, c};
        return t;
    endfunction

    task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // inputs change just after a falling edge; outputs read one cycle later
    task automatic drive(logic [3:0] c, logic ch, logic i, logic e);
        state_code = c;
        state_chg  = ch;
        in_idle    = i;
        in_error   = e;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        state_code = 4'd9;
        state_chg = 1'b1;
        in_idle = 1'b0;
        in_error = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sig", sig, SEED);
        chk("R1 save_req", {9'd0, save_req}, 10'd0);
        chk("R1 save_sig", save_sig, 10'd0);
        rst = 1'b0;
        drive(C_IDLE, 1'b0, 1'b1, 1'b0);
        chk("R4 idle after reset", sig, SEED);
    endtask

    task automatic t_fold_and_hold();
        logic [9:0] m;
        m = SEED;
        for (int i = 0; i < 12; i++) begin
            logic [3:0] c;
            c = 4'((i * 5 + 3) % 13 + 1);
            drive(c, 1'b1, 1'b0, 1'b0);
            m = model_fold(m, c);
            chk("R2 fold step", sig, m);
            chk("R7 no save mid path", {9'd0, save_req}, 10'd0);
            drive(4'hA, 1'b0, 1'b0, 1'b0);
            chk("R3 hold without change", sig, m);
        end
        drive(4'h6, 1'b0, 1'b0, 1'b1);
        chk("R3 hold with error flag only", sig, m);
        drive(C_IDLE, 1'b0, 1'b1, 1'b0);
        chk("R4 reseed in idle", sig, SEED);
        chk("R7 no save on idle rest", {9'd0, save_req}, 10'd0);
    endtask

    task automatic t_end(bit to_err);
        logic [9:0] m;
        logic [3:0] tc;
        m = SEED;
        drive(4'd1, 1'b1, 1'b0, 1'b0); m = model_fold(m, 4'd1);
        drive(4'd4, 1'b1, 1'b0, 1'b0); m = model_fold(m, 4'd4);
        drive(4'd5, 1'b1, 1'b0, 1'b0); m = model_fold(m, 4'd5);
        tc = to_err ? C_ERR : C_IDLE;
        drive(tc, 1'b1, !to_err, to_err);
        m = model_fold(m, tc);
        if (to_err) begin
            chk("R6 save_req", {9'd0, save_req}, 10'd1);
            chk("R6 save_sig", save_sig, m);
            chk("R6 reseed", sig, SEED);
            drive(C_ERR, 1'b0, 1'b0, 1'b1);
            chk("R3 rest in error", sig, SEED);
        end else begin
            chk("R5 save_req", {9'd0, save_req}, 10'd1);
            chk("R5 save_sig", save_sig, m);
            chk("R5 reseed", sig, SEED);
            drive(C_IDLE, 1'b0, 1'b1, 1'b0);
        end
        chk("R7 pulse ends", {9'd0, save_req}, 10'd0);
        chk("R7 save_sig held", save_sig, m);
        drive(C_IDLE, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_err_from_idle();
        drive(C_ERR, 1'b1, 1'b0, 1'b1);
        chk("R6 direct error save_req", {9'd0, save_req}, 10'd1);
        chk("R6 direct error save_sig", save_sig, model_fold(SEED, C_ERR));
        chk("R6 direct error reseed", sig, SEED);
        drive(C_IDLE, 1'b1, 1'b1, 1'b0);
        chk("R5 error to idle save", save_sig, model_fold(SEED, C_IDLE));
        drive(C_IDLE, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_unique();
        logic [9:0] got [24];
        int k;
        k = 0;
        for (int xi = 0; xi < 12; xi++) begin
            for (int ti = 0; ti < 2; ti++) begin
                logic [3:0] x;
                logic [3:0] tc;
                logic [9:0] m;
                x  = 4'(xi + 2);
                tc = (ti == 1) ? C_ERR : C_IDLE;
                m  = SEED;
                drive(4'd1, 1'b1, 1'b0, 1'b0); m = model_fold(m, 4'd1);
                drive(x,    1'b1, 1'b0, 1'b0); m = model_fold(m, x);
                drive(4'd3, 1'b1, 1'b0, 1'b0); m = model_fold(m, 4'd3);
                drive(tc, 1'b1, ti == 0, ti == 1);
                m = model_fold(m, tc);
                chk("R8 path signature", save_sig, m);
                chk("R8 save strobe", {9'd0, save_req}, 10'd1);
                got[k] = save_sig;
                k++;
            end
        end
        for (int a = 0; a < 24; a++) begin
            for (int b = a + 1; b < 24; b++) begin
                n_vec++;
                if (got[a] == got[b]) begin
                    n_bad++;
                    $display("FAIL R8 collision paths %0d/%0d: actual %h expected distinct from %h",
                             a, b, got[b], got[a]);
                end
            end
        end
        drive(C_IDLE, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fold_and_hold();
        t_end(1'b0);
        t_end(1'b1);
        t_err_from_idle();
        t_unique();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule